// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port

This block controls one parallel I/O port of `WIDTH` pins. Each pin has three configuration bits: a direction bit that decides whether the pad driver is enabled, a threshold bit that picks TTL or CMOS input levels, and a pull-up bit that asks for a weak pull-up. The port also has an output data latch. The block drives all of these to the pad ring as control outputs. The pad itself and its analog behaviour live outside the block.

Commands arrive one per clock on a small command bus:
- A target-select command stores a 2-bit code. That code decides which register the later write and read commands address.
- A read of the data target returns the pin levels after a synchroniser, not the latch. A pin that is driven high but held low from outside therefore reads 0.
- Bit set and bit clear are read-modify-write operations on the whole port. For output pins the source value comes from the latch. For input pins it comes from the synchronised pin level.
- A bit operation writes its result back one cycle after it is issued. An internal forwarding path hands that pending result to the next bit operation, so bit operations issued on consecutive cycles never lose an update.

Top module: `cfg_io_port`

## Requirements
- R1: After reset every pin is an input (`pad_oe` = 0), every threshold is CMOS (`pad_ttl` = 0), every pull-up is off (`pad_pu` = 0), the output latch is 0 (`pad_out` = 0), and the selected target code is 0.
- R2: `cmd_op` encodes 0 idle, 1 select target (the code is taken from `cmd_wdata[1:0]`), 2 write, 3 read, 4 set bit, 5 clear bit. The target codes are 0 output latch, 1 direction (1 = output), 2 threshold (1 = TTL, 0 = CMOS), 3 pull-up (1 = enabled).
- R3: A write loads `cmd_wdata` into the currently selected register only. The new value appears on the pad outputs right after the clock edge that samples the write.
- R4: `pad_oe` equals the direction register, `pad_out` equals the output latch, and `pad_ttl` equals the threshold register.
- R5: `pad_pu` is high only for pins whose pull-up bit is set and whose direction is input.
- R6: A read with target 0 returns the synchronised pin levels and never the latch. With the default two synchroniser stages, a pin change made before clock edge E is seen by reads sampled at edge E+2 or later, and is not seen by reads sampled at E or E+1.
- R7: A read with target 1, 2 or 3 returns that configuration register. For every read, `rd_data` holds the result from the clock edge after the read is sampled.
- R8: Set bit and clear bit on index `cmd_idx` compute a base word and write it back with only that bit forced to 1 or 0. The base word takes the latch value on output pins and the synchronised pin value on input pins. The result appears on `pad_out` two clock edges after the command is sampled.
- R9: Bit operations issued on consecutive cycles each act on the result of the one before them. No update is lost, including repeated operations on the same bit.
- R10: A latch write issued in the cycle right after a bit operation overrides that bit operation's write-back.
- R11: Idle and target-select commands leave all pad outputs unchanged.
- R12: `rd_valid` is high for exactly the one cycle after each read command and low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_idx | input | $clog2(WIDTH) | Bit index for set and clear |
| cmd_wdata | input | WIDTH | Write data; bits [1:0] carry the target code for a select command |
| rd_data | output | WIDTH | Read result |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a new read result |
| pad_in | input | WIDTH | Asynchronous pin levels from the pads |
| pad_oe | output | WIDTH | Output driver enable per pin |
| pad_out | output | WIDTH | Output level per pin |
| pad_ttl | output | WIDTH | Input threshold select per pin (1 = TTL) |
| pad_pu | output | WIDTH | Weak pull-up enable per pin |

## Verification
A wrong configuration or target register shows up on the pad outputs or in read data one edge after the write that should have set it. A broken forwarding path or a broken write-back priority only shows up when bit operations run back to back: the final latch value comes out wrong two edges after the last command. The bench therefore sweeps every bit index under several direction patterns, both as isolated operations and as back-to-back chains. A wrong synchroniser depth moves the cycle in which a pin change first reaches read data, and the bench probes that cycle exactly.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_MODE  = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_SETB  = 3'd4,
    OP_CLRB  = 3'd5
  } io_op_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_THR  = 2'd2,
    SEL_PULL = 2'd3
  } io_sel_e;

endpackage

// File: rtl/cfg_io_sync.sv
// Multi-stage synchroniser for the asynchronous pad inputs.
module cfg_io_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] d;
    if (s == 0) begin : g_first
      assign d = async_in;
    end else begin : g_next
      assign d = g_stage[s-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  assign sync_out = g_stage[STAGES-1].q;

endmodule

// File: rtl/cfg_io_cfg.sv
// Target select plus direction, threshold and pull-up registers.
module cfg_io_cfg
  import cfg_io_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] wdata,
  output logic [1:0]       mode,
  output logic [WIDTH-1:0] dir,
  output logic [WIDTH-1:0] thr,
  output logic [WIDTH-1:0] pull
);

  logic [1:0]       mode_q;
  logic [WIDTH-1:0] dir_q, thr_q, pull_q;
  logic             mode_en, dir_en, thr_en, pull_en, wr_hit;

  always_comb begin
    wr_hit  = (op == OP_WRITE);
    mode_en = (op == OP_MODE);
    dir_en  = wr_hit && (mode_q == SEL_DIR);
    thr_en  = wr_hit && (mode_q == SEL_THR);
    pull_en = wr_hit && (mode_q == SEL_PULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SEL_DATA;
      dir_q  <= '0;
      thr_q  <= '0;
      pull_q <= '0;
    end else begin
      if (mode_en) mode_q <= wdata[1:0];
      if (dir_en)  dir_q  <= wdata;
      if (thr_en)  thr_q  <= wdata;
      if (pull_en) pull_q <= wdata;
    end
  end

  assign mode = mode_q;
  assign dir  = dir_q;
  assign thr  = thr_q;
  assign pull = pull_q;

endmodule

// File: rtl/cfg_io_latch.sv
// Output latch with a two-stage bit read-modify-write pipeline and forwarding.
module cfg_io_latch
  import cfg_io_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               op,
  input  logic [$clog2(WIDTH)-1:0] idx,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [1:0]               mode,
  input  logic [WIDTH-1:0]         dir,
  input  logic [WIDTH-1:0]         pin_s,
  output logic [WIDTH-1:0]         latch
);

  localparam int IDX_W = $clog2(WIDTH);

  logic [WIDTH-1:0] latch_q, latch_d;
  logic             latch_en;
  logic             pend_vld_q, pend_set_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [WIDTH-1:0] pend_base_q;

  logic [WIDTH-1:0] pend_mask, pend_res, latch_view, base_d;
  logic             is_bit, is_set, direct_wr;

  always_comb begin
    pend_mask  = WIDTH'(1) << pend_idx_q;
    pend_res   = pend_set_q ? (pend_base_q | pend_mask)
                            : (pend_base_q & ~pend_mask);
    // Forward the pending write-back into the operand of a following op.
    latch_view = pend_vld_q ? pend_res : latch_q;
    is_set     = (op == OP_SETB);
    is_bit     = is_set || (op == OP_CLRB);
    base_d     = (dir & latch_view) | (~dir & pin_s);
    direct_wr  = (op == OP_WRITE) && (mode == SEL_DATA);
    latch_en   = direct_wr || pend_vld_q;
    latch_d    = direct_wr ? wdata : pend_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q  <= 1'b0;
      pend_set_q  <= 1'b0;
      pend_idx_q  <= '0;
      pend_base_q <= '0;
      latch_q     <= '0;
    end else begin
      pend_vld_q <= is_bit;
      if (is_bit) begin
        pend_set_q  <= is_set;
        pend_idx_q  <= idx;
        pend_base_q <= base_d;
      end
      if (latch_en) latch_q <= latch_d;
    end
  end

  assign latch = latch_q;

endmodule

// File: rtl/cfg_io_rdback.sv
// Registered read-back multiplexer.
module cfg_io_rdback
  import cfg_io_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] pin_s,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] thr,
  input  logic [WIDTH-1:0] pull,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);

  logic [WIDTH-1:0] sel_val, rd_data_q;
  logic             rd_en, rd_valid_q;

  always_comb begin
    rd_en = (op == OP_READ);
    unique case (mode)
      SEL_DATA: sel_val = pin_s;
      SEL_DIR:  sel_val = dir;
      SEL_THR:  sel_val = thr;
      default:  sel_val = pull;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= sel_val;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               cmd_op,
  input  logic [$clog2(WIDTH)-1:0] cmd_idx,
  input  logic [WIDTH-1:0]         cmd_wdata,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     rd_valid,
  input  logic [WIDTH-1:0]         pad_in,
  output logic [WIDTH-1:0]         pad_oe,
  output logic [WIDTH-1:0]         pad_out,
  output logic [WIDTH-1:0]         pad_ttl,
  output logic [WIDTH-1:0]         pad_pu
);

  logic [1:0]       mode_w;
  logic [WIDTH-1:0] dir_w, thr_w, pull_w, pin_s_w, latch_w;

  cfg_io_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_s_w)
  );

  cfg_io_cfg #(.WIDTH(WIDTH)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (cmd_op),
    .wdata (cmd_wdata),
    .mode  (mode_w),
    .dir   (dir_w),
    .thr   (thr_w),
    .pull  (pull_w)
  );

  cfg_io_latch #(.WIDTH(WIDTH)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (cmd_op),
    .idx   (cmd_idx),
    .wdata (cmd_wdata),
    .mode  (mode_w),
    .dir   (dir_w),
    .pin_s (pin_s_w),
    .latch (latch_w)
  );

  cfg_io_rdback #(.WIDTH(WIDTH)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (cmd_op),
    .mode     (mode_w),
    .pin_s    (pin_s_w),
    .dir      (dir_w),
    .thr      (thr_w),
    .pull     (pull_w),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    assign pad_oe[i]  = dir_w[i];
    assign pad_out[i] = latch_w[i];
    assign pad_ttl[i] = thr_w[i];
    assign pad_pu[i]  = pull_w[i] & ~dir_w[i];
  end

endmodule

// File: rtl/cfg_io_port_chk.sv
module cfg_io_port_chk
  import cfg_io_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               cmd_op,
  input logic [$clog2(WIDTH)-1:0] cmd_idx,
  input logic [WIDTH-1:0]         cmd_wdata,
  input logic [WIDTH-1:0]         rd_data,
  input logic                     rd_valid,
  input logic [WIDTH-1:0]         pad_oe,
  input logic [WIDTH-1:0]         pad_out,
  input logic [WIDTH-1:0]         pad_ttl,
  input logic [WIDTH-1:0]         pad_pu,
  input logic [1:0]               mode
);

  assert_pull_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == ($past(cmd_op) == OP_READ));

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_WRITE && mode == SEL_DIR) |=> pad_oe == $past(cmd_wdata));

  assert_dir_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_READ && mode == SEL_DIR) |=> rd_data == $past(pad_oe));

  assert_setb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_SETB) ##1 !(cmd_op == OP_WRITE && mode == SEL_DATA)
    |=> pad_out[$past(cmd_idx, 2)] == 1'b1);

  assert_clrb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_CLRB) ##1 !(cmd_op == OP_WRITE && mode == SEL_DATA)
    |=> pad_out[$past(cmd_idx, 2)] == 1'b0);

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_op == OP_NOP || cmd_op == OP_MODE) &&
     $past(cmd_op) != OP_SETB && $past(cmd_op) != OP_CLRB)
    |=> $stable(pad_out) && $stable(pad_oe) && $stable(pad_ttl) && $stable(pad_pu));

endmodule

bind cfg_io_port cfg_io_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_op    (cmd_op),
  .cmd_idx   (cmd_idx),
  .cmd_wdata (cmd_wdata),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_ttl   (pad_ttl),
  .pad_pu    (pad_pu),
  .mode      (mode_w)
);

// File: tb/cfg_io_port_tb.sv
`timescale 1ns/1ps
module cfg_io_port_tb;
  import cfg_io_pkg::*;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   op;
  logic [2:0]   idx;
  logic [W-1:0] wd, pin;
  logic [W-1:0] rd_data, pad_oe, pad_out, pad_ttl, pad_pu;
  logic         rd_valid;

  int n_chk = 0;
  int n_fail = 0;

  logic [W-1:0] m_dir, m_thr, m_pull, m_lat;
  int           m_mode;

  always #2.5 clk = ~clk;

  cfg_io_port #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(op), .cmd_idx(idx), .cmd_wdata(wd),
    .rd_data(rd_data), .rd_valid(rd_valid), .pad_in(pin),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_ttl(pad_ttl), .pad_pu(pad_pu)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input int i, input logic [W-1:0] d);
    op = o; idx = 3'(i); wd = d;
    @(negedge clk);
    op = OP_NOP;
  endtask

  task automatic idle(input int n);
    op = OP_NOP;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int m);
    issue(OP_MODE, 0, W'(m));
    m_mode = m;
  endtask

  task automatic wr(input logic [W-1:0] d);
    issue(OP_WRITE, 0, d);
    case (m_mode)
      0: m_lat = d;
      1: m_dir = d;
      2: m_thr = d;
      default: m_pull = d;
    endcase
  endtask

  task automatic bop(input bit s, input int i);
    logic [W-1:0] base;
    base  = (m_dir & m_lat) | (~m_dir & pin);
    m_lat = s ? (base | (W'(1) << i)) : (base & ~(W'(1) << i));
    issue(s ? OP_SETB : OP_CLRB, i, '0);
  endtask

  task automatic rd(input string tag);
    logic [W-1:0] e;
    case (m_mode)
      0: e = pin;
      1: e = m_dir;
      2: e = m_thr;
      default: e = m_pull;
    endcase
    issue(OP_READ, 0, '0);
    chk({tag, " rd_data"}, rd_data, e);
    chk("R12 rd_valid after read", W'(rd_valid), W'(1));
  endtask

  task automatic pads(input string tag);
    chk({tag, " pad_oe R4"}, pad_oe, m_dir);
    chk({tag, " pad_out R4"}, pad_out, m_lat);
    chk({tag, " pad_ttl R4"}, pad_ttl, m_thr);
    chk({tag, " pad_pu R5"}, pad_pu, m_pull & ~m_dir);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] pats [5];
    logic [W-1:0] vals [6];
    pats = '{8'h00, 8'hFF, 8'h0F, 8'hA5, 8'h5A};
    vals = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h3C, 8'h81};
    rst_n = 1'b0; op = OP_NOP; idx = '0; wd = '0; pin = '0;
    m_dir = '0; m_thr = '0; m_pull = '0; m_lat = '0; m_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    pads("R1 reset");
    chk("R12 rd_valid idle", W'(rd_valid), W'(0));
    rd("R1 target 0 after reset");

    // R2 R3 R7: each target written and read back, others untouched
    for (int m = 1; m < 4; m++) begin
      set_mode(m);
      foreach (vals[k]) begin
        wr(vals[k]);
        pads("R2 R3 write");
        rd("R7 readback");
      end
    end
    set_mode(2); wr(8'h00);

    // R5: pull-up masked by direction, all direction codes
    set_mode(3); wr(8'hFF);
    set_mode(1);
    for (int d = 0; d < 256; d++) begin
      wr(W'(d));
      chk("R5 pull masked", pad_pu, ~W'(d));
    end

    // R6: reads show pins, not latch; synchroniser latency
    wr(8'hFF);
    set_mode(0); wr(8'hFF);
    pin = 8'h0F; idle(3);
    rd("R6 pins not latch");
    pin = 8'hC3;
    issue(OP_READ, 0, '0); chk("R6 sampled E", rd_data, 8'h0F);
    issue(OP_READ, 0, '0); chk("R6 sampled E+1", rd_data, 8'h0F);
    issue(OP_READ, 0, '0); chk("R6 sampled E+2", rd_data, 8'hC3);
    idle(1);
    chk("R12 rd_valid low after idle", W'(rd_valid), W'(0));

    // R8: isolated bit ops, all indices, several direction patterns
    pin = 8'h96; idle(3);
    foreach (pats[p]) begin
      set_mode(1); wr(pats[p]);
      set_mode(0); wr(8'h3C);
      for (int i = 0; i < W; i++) begin
        bop(1'b1, i); idle(1);
        chk("R8 set bit", pad_out, m_lat);
        bop(1'b0, i); idle(1);
        chk("R8 clear bit", pad_out, m_lat);
      end
    end

    // R9: back-to-back chains
    set_mode(1); wr(8'hFF);
    set_mode(0); wr(8'h00);
    for (int i = 0; i < W; i++) bop(1'b1, i);
    idle(1);
    chk("R9 set chain", pad_out, 8'hFF);
    for (int i = 0; i < W; i += 2) bop(1'b0, i);
    idle(1);
    chk("R9 clear chain", pad_out, 8'hAA);
    bop(1'b1, 0); bop(1'b0, 0); bop(1'b1, 0); bop(1'b0, 0);
    idle(1);
    chk("R9 same bit toggle", pad_out, m_lat);
    set_mode(1); wr(8'h0F);
    set_mode(0);
    bop(1'b1, 6); bop(1'b0, 2); bop(1'b1, 3); bop(1'b0, 7);
    idle(1);
    chk("R9 mixed direction chain", pad_out, m_lat);

    // R10: direct write right after a bit op wins
    set_mode(1); wr(8'hFF); set_mode(0);
    bop(1'b1, 5); wr(8'h42);
    idle(1);
    chk("R10 write overrides", pad_out, 8'h42);
    wr(8'h10); bop(1'b1, 0);
    idle(1);
    chk("R10 bit op after write", pad_out, 8'h11);

    // R11: idle and target-select leave pads alone
    set_mode(2); wr(8'h3C);
    set_mode(3); wr(8'h81);
    set_mode(0); set_mode(1); set_mode(2);
    idle(5);
    pads("R11 stable");
    chk("R12 rd_valid after select", W'(rd_valid), W'(0));

    finish_run();
  end

endmodule